// File: doc/BRIEF.md
# Byte-Command I2C Master Engine

This block is an I2C bus master that does one bus primitive per software command. Software writes a command byte with its launch bit set. The engine then runs a start condition, a repeated start, a byte transmit with acknowledge check, a byte receive ending in ACK or NACK, or a stop condition. When the primitive is done, the engine records a two-bit completion status and sets an interrupt flag. Software builds whole transfers from these primitives: address byte, data bytes and stop are each one command.

The block has a byte-wide register port, with a registered read path that returns data one cycle after the read strobe. The bus lines are open-drain: the block gives active-high pull-low enables for SCL and SDA and samples SDA as it appears on the wire. An 8-bit divider value sets the bus rate. Each SCL period is four equal quarters. Each quarter lasts 16 × (divider + 1) clock cycles. The level pattern of each primitive is fixed quarter by quarter.

Top module: `i2cb_master`

## Requirements
- R1: Register offsets: 0x0 control (bit 0 = local reset), 0x1 divider, 0x2 command/status, 0x3 data, 0x8 flag clear, 0xA interrupt enable (bit 0). A read strobe returns the addressed value on the read data bus after the next clock edge. Divider, data, enable and flag (bit 0 at 0x8) read back as held.
- R2: While control bit 0 is 1, both line enables are 0, the engine is idle, and launch writes are ignored. Leaving local reset forgets any open bus session.
- R3: A write to 0x2 with bit 7 set launches opcode bits 3:0. Command readback is {busy, status[1:0], 0, last opcode}, with busy in bit 7 and status in bits 6:5. A write with bit 7 clear, or any command write while busy is 1, has no effect.
- R4: Every quarter lasts exactly 16 × (divider + 1) cycles. Start, repeated start and stop take 4 quarters. A byte command takes 36 quarters (9 bits). Completion falls on the edge that ends the last quarter.
- R5: Opcode 1 (start) drives the pull-low pattern (SCL, SDA) per quarter: (0,0), (0,1), (0,1), (1,1). Opcode 2 (repeated start) drives (1,0), (0,0), (0,1), (1,1). Opcode 10 (stop) drives (1,1), (0,1), (0,0), (0,0) and then releases the bus. Between commands of an open session, SCL is held low and SDA keeps its last level.
- R6: Opcode 3 transmits the data register MSB first. The line is pulled low for a 0 bit. In each bit, SCL is pulled in quarters 0 and 3. The ninth bit releases SDA, and SDA is sampled at the end of quarter 1. Status is 1 if SDA was low (acknowledged) and 2 if it was high.
- R7: Opcode 6 or 7 receives 8 bits MSB first, each sampled at the end of quarter 1. In the ninth bit, SDA is pulled low for opcode 6 and released for opcode 7. Status is 0, and the data register then returns the received byte.
- R8: The command aborts in the launch cycle with status 3 and no change on either line in these cases: opcode 2, 3, 6, 7 or 10 with no open session; opcode 1 while a session is open; any other opcode.
- R9: Every completion, aborts included, sets the flag. irq equals the flag AND enable bit 0. Writing 0x8 with bit 0 set clears the flag.
- R10: Outside start, repeated start and stop, a change of the SDA enable happens only while SCL is pulled low in both the cycle before and the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA level on the wire |

## Verification
The quarter counter's range assertion assumes the divider is not rewritten while a command is busy. The stimulus changes the divider only between commands. The SDA-change and sampling properties assume sda_in is the wired AND of the block's own pull and a target's pull. The stimulus builds it exactly that way, and the target model changes its pull only at cycle boundaries inside a bit. Register strobes are driven on the falling edge and are one cycle long, so the block never sees a launch and a local-reset write in the same cycle.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  localparam int REG_W = 8;

  localparam int A_CTRL   = 0;
  localparam int A_DIV    = 1;
  localparam int A_CMD    = 2;
  localparam int A_DATA   = 3;
  localparam int A_IRQCLR = 8;
  localparam int A_IRQEN  = 10;

  localparam logic [3:0] OP_START     = 4'd1;
  localparam logic [3:0] OP_RSTART    = 4'd2;
  localparam logic [3:0] OP_WRITE     = 4'd3;
  localparam logic [3:0] OP_READ_ACK  = 4'd6;
  localparam logic [3:0] OP_READ_NACK = 4'd7;
  localparam logic [3:0] OP_STOP      = 4'd10;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ACK   = 2'd1,
    ST_NACK  = 2'd2,
    ST_ABORT = 2'd3
  } cmd_status_e;

  typedef enum logic [2:0] {
    K_IDLE, K_START, K_RSTART, K_WR, K_RD, K_STOP
  } cmd_kind_e;

  // cycles in one quarter of an SCL period
  function automatic int quarter_len(input int div_val, input int mult);
    return mult * (div_val + 1);
  endfunction

  function automatic cmd_kind_e decode_op(input logic [3:0] op);
    case (op)
      OP_START:                 return K_START;
      OP_RSTART:                return K_RSTART;
      OP_WRITE:                 return K_WR;
      OP_READ_ACK, OP_READ_NACK: return K_RD;
      OP_STOP:                  return K_STOP;
      default:                  return K_IDLE;
    endcase
  endfunction

  // a start opens a session, everything else needs one
  function automatic logic op_legal(input cmd_kind_e k, input logic held);
    case (k)
      K_IDLE:  return 1'b0;
      K_START: return !held;
      default: return held;
    endcase
  endfunction

  // {scl_low, sda_low} for the condition commands, per quarter
  function automatic logic [1:0] edge_drive(input cmd_kind_e k, input logic [1:0] q);
    case (k)
      K_START:  return {q == 2'd3, q != 2'd0};
      K_RSTART: return {(q == 2'd0) || (q == 2'd3), q[1]};
      K_STOP:   return {q == 2'd0, !q[1]};
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/i2cb_qtimer.sv
module i2cb_qtimer #(
  parameter int DIV_W    = 8,
  parameter int QTR_MULT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import i2cb_pkg::*;

  localparam int CNT_W = $clog2(QTR_MULT * (1 << DIV_W)) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;

  assign len_m1 = CNT_W'(quarter_len(int'(div), QTR_MULT) - 1);
  assign tick   = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (restart) cnt_q <= len_m1;
    else if (run)     cnt_q <= (cnt_q == '0) ? len_m1 : cnt_q - 1'b1;
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    run |-> (cnt_q <= len_m1));

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lrst,
  input  logic              launch,
  input  logic [3:0]        launch_op,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sda_in,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_status,
  output logic              rx_load,
  output logic [DATA_W-1:0] rx_byte,
  output logic              timer_restart,
  output logic              scl_oe,
  output logic              sda_oe
);
  import i2cb_pkg::*;

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W);

  cmd_kind_e         kind_q;
  logic [1:0]        q_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              ack_low_q;
  logic              nack_q;
  logic              held_q;
  logic              hold_low_q;

  cmd_kind_e launch_kind;
  logic      launch_ok, abort_now;
  logic      is_byte, last_step, fin, sample_evt, edge_cmd;
  logic      scl_low, sda_low, byte_sda_low;

  assign launch_kind   = decode_op(launch_op);
  assign launch_ok     = launch && op_legal(launch_kind, held_q);
  assign abort_now     = launch && !op_legal(launch_kind, held_q);
  assign timer_restart = launch_ok;

  assign busy       = (kind_q != K_IDLE);
  assign is_byte    = (kind_q == K_WR) || (kind_q == K_RD);
  assign edge_cmd   = busy && !is_byte;
  assign last_step  = is_byte ? (bit_q == LAST_BIT) : 1'b1;
  assign fin        = busy && tick && (q_q == 2'd3) && last_step;
  assign sample_evt = busy && tick && (q_q == 2'd1) && is_byte;

  always_comb begin
    if (bit_q < LAST_BIT) byte_sda_low = (kind_q == K_WR) ? !sh_q[DATA_W-1] : 1'b0;
    else                  byte_sda_low = (kind_q == K_WR) ? 1'b0 : !nack_q;
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (kind_q)
      K_IDLE: begin
        scl_low = held_q;
        sda_low = held_q && hold_low_q;
      end
      K_WR, K_RD: begin
        scl_low = (q_q == 2'd0) || (q_q == 2'd3);
        sda_low = byte_sda_low;
      end
      default: {scl_low, sda_low} = edge_drive(kind_q, q_q);
    endcase
  end

  assign scl_oe = !lrst && scl_low;
  assign sda_oe = !lrst && sda_low;

  assign done        = fin || abort_now;
  assign rx_load     = fin && (kind_q == K_RD);
  assign rx_byte     = sh_q;
  assign done_status = abort_now ? ST_ABORT :
                       (kind_q == K_WR) ? (ack_low_q ? ST_ACK : ST_NACK) : ST_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE; q_q <= '0; bit_q <= '0; sh_q <= '0;
      ack_low_q <= 1'b0; nack_q <= 1'b0; held_q <= 1'b0; hold_low_q <= 1'b0;
    end else if (lrst) begin
      kind_q <= K_IDLE; q_q <= '0; bit_q <= '0;
      held_q <= 1'b0; hold_low_q <= 1'b0;
    end else if (launch_ok) begin
      kind_q    <= launch_kind;
      q_q       <= '0;
      bit_q     <= '0;
      sh_q      <= tx_byte;
      ack_low_q <= 1'b0;
      nack_q    <= (launch_op == OP_READ_NACK);
    end else if (busy && tick) begin
      if (sample_evt) begin
        if (bit_q < LAST_BIT && kind_q == K_RD) sh_q <= {sh_q[DATA_W-2:0], sda_in};
        if (bit_q == LAST_BIT && kind_q == K_WR) ack_low_q <= !sda_in;
      end
      if (q_q == 2'd3) begin
        q_q <= '0;
        if (fin) begin
          kind_q <= K_IDLE;
          case (kind_q)
            K_START, K_RSTART: begin held_q <= 1'b1; hold_low_q <= 1'b1; end
            K_STOP:            begin held_q <= 1'b0; hold_low_q <= 1'b0; end
            K_WR:              hold_low_q <= 1'b0;
            K_RD:              hold_low_q <= !nack_q;
            default:           ;
          endcase
        end else begin
          bit_q <= bit_q + 1'b1;
          if (kind_q == K_WR && bit_q < LAST_BIT) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end
      end else begin
        q_q <= q_q + 1'b1;
      end
    end
  end

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n || lrst)
    (!edge_cmd && !$past(edge_cmd) && !$past(lrst) && (sda_oe != $past(sda_oe)))
      |-> (scl_oe && $past(scl_oe)));

  // R6
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n || lrst)
    sample_evt |-> !scl_oe);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || lrst)
    abort_now |=> (!busy && $stable(scl_oe) && $stable(sda_oe)));

  // R3
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || lrst)
    fin |=> !busy);

  // R2
  lrst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lrst) |-> !busy);

endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [i2cb_pkg::REG_W-1:0] wdata,
  input  logic                       wr,
  input  logic                       rd,
  output logic [i2cb_pkg::REG_W-1:0] rdata,
  input  logic                       busy,
  input  logic                       done,
  input  logic [1:0]                 done_status,
  input  logic                       rx_load,
  input  logic [i2cb_pkg::REG_W-1:0] rx_byte,
  output logic                       lrst,
  output logic [DIV_W-1:0]           div,
  output logic [i2cb_pkg::REG_W-1:0] tx_byte,
  output logic                       launch,
  output logic [3:0]                 launch_op,
  output logic                       irq
);
  import i2cb_pkg::*;

  logic             lrst_q, en_q, flag_q;
  logic [DIV_W-1:0] div_q;
  logic [REG_W-1:0] data_q, rdata_q;
  logic [3:0]       op_q;
  logic [1:0]       status_q;

  logic hit_ctrl, hit_div, hit_cmd, hit_data, hit_clr, hit_en, clr_req;

  assign hit_ctrl = wr && (addr == ADDR_W'(A_CTRL));
  assign hit_div  = wr && (addr == ADDR_W'(A_DIV));
  assign hit_cmd  = wr && (addr == ADDR_W'(A_CMD));
  assign hit_data = wr && (addr == ADDR_W'(A_DATA));
  assign hit_clr  = wr && (addr == ADDR_W'(A_IRQCLR));
  assign hit_en   = wr && (addr == ADDR_W'(A_IRQEN));
  assign clr_req  = hit_clr && wdata[0];

  assign launch    = hit_cmd && wdata[REG_W-1] && !busy && !lrst_q;
  assign launch_op = wdata[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrst_q <= 1'b0; en_q <= 1'b0; flag_q <= 1'b0; div_q <= '0;
      data_q <= '0; op_q <= '0; status_q <= '0; rdata_q <= '0;
    end else begin
      if (hit_ctrl) lrst_q <= wdata[0];
      if (hit_div)  div_q  <= wdata[DIV_W-1:0];
      if (hit_en)   en_q   <= wdata[0];
      if (rx_load)       data_q <= rx_byte;
      else if (hit_data) data_q <= wdata;
      if (done)         flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (launch) op_q     <= launch_op;
      if (done)   status_q <= done_status;
      if (rd) begin
        case (int'(addr))
          A_CTRL:   rdata_q <= {{(REG_W-1){1'b0}}, lrst_q};
          A_DIV:    rdata_q <= REG_W'(div_q);
          A_CMD:    rdata_q <= {busy, status_q, 1'b0, op_q};
          A_DATA:   rdata_q <= data_q;
          A_IRQCLR: rdata_q <= {{(REG_W-1){1'b0}}, flag_q};
          A_IRQEN:  rdata_q <= {{(REG_W-1){1'b0}}, en_q};
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign lrst    = lrst_q;
  assign div     = div_q;
  assign tx_byte = data_q;
  assign rdata   = rdata_q;
  assign irq     = flag_q && en_q;

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_req));

  // R3
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && busy) |=> $stable(op_q));

endmodule

// File: rtl/i2cb_master.sv
module i2cb_master #(
  parameter int ADDR_W   = 4,
  parameter int DIV_W    = 8,
  parameter int QTR_MULT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  import i2cb_pkg::*;

  logic             lrst, launch, busy, done, rx_load, tick, timer_restart;
  logic [3:0]       launch_op;
  logic [1:0]       done_status;
  logic [DIV_W-1:0] div;
  logic [REG_W-1:0] tx_byte, rx_byte;

  i2cb_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata),
    .busy(busy), .done(done), .done_status(done_status),
    .rx_load(rx_load), .rx_byte(rx_byte),
    .lrst(lrst), .div(div), .tx_byte(tx_byte),
    .launch(launch), .launch_op(launch_op), .irq(irq)
  );

  i2cb_qtimer #(.DIV_W(DIV_W), .QTR_MULT(QTR_MULT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(lrst), .restart(timer_restart),
    .run(busy), .div(div), .tick(tick)
  );

  i2cb_engine #(.DATA_W(REG_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .lrst(lrst), .launch(launch),
    .launch_op(launch_op), .tx_byte(tx_byte), .sda_in(sda_in), .tick(tick),
    .busy(busy), .done(done), .done_status(done_status),
    .rx_load(rx_load), .rx_byte(rx_byte), .timer_restart(timer_restart),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

endmodule

// File: tb/sim_i2cb_master.sv
module sim_i2cb_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe, sda_in;
  logic       slv_low = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench-side model of the block
  int   cur_len = 16;
  bit   m_held = 0, m_hold_low = 0, m_en = 0;
  logic [7:0] m_data = '0;

  always #2 clk = ~clk;
  assign sda_in = ~(sda_oe | slv_low);

  i2cb_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output int v);
    reg_addr = 4'(a); reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic idle_lines(input string req);
    chk(scl_oe == m_held, req, "idle scl_oe", scl_oe, m_held);
    chk(sda_oe == (m_held && m_hold_low), req, "idle sda_oe", sda_oe, m_held && m_hold_low);
  endtask

  task automatic done_checks(input int op, input int st, input string req);
    int v;
    reg_read(2, v);
    chk(v == ((st << 5) | op), req, "command readback", v, (st << 5) | op);
    chk(irq == m_en, "R9", "irq after completion", irq, m_en);
    reg_read(8, v);
    chk(v == 1, "R9", "flag after completion", v, 1);
    reg_write(8, 1);
    chk(irq == 0, "R9", "irq after clear", irq, 0);
  endtask

  // expected {scl_low, sda_low} written from the requirement tables
  function automatic logic [1:0] want(input int op, input int q, input int b, input logic [7:0] tx);
    logic [3:0] s, d;
    case (op)
      1:  begin s = 4'b1000; d = 4'b1110; end
      2:  begin s = 4'b1001; d = 4'b1100; end
      10: begin s = 4'b0001; d = 4'b0011; end
      default: begin
        s = 4'b1001;
        if (op == 3) d = (b < 8 && !tx[7-b]) ? 4'b1111 : 4'b0000;
        else         d = (b == 8 && op == 6) ? 4'b1111 : 4'b0000;
      end
    endcase
    return {s[q], d[q]};
  endfunction

  task automatic run_cmd(input int op, input logic [7:0] slv_byte, input bit slv_ack,
                         input bit inject, input int st, input string req);
    int nq, bad, first_c, first_act, first_exp;
    nq = (op == 3 || op == 6 || op == 7) ? 36 : 4;
    bad = 0; first_c = 0; first_act = 0; first_exp = 0;
    reg_addr = 4'd2; reg_wdata = 8'(8'h80 | op); reg_wr = 1'b1;
    @(posedge clk);
    for (int c = 0; c < nq * cur_len; c++) begin
      int qi, q, b;
      logic [1:0] e;
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
      qi = c / cur_len; q = qi % 4; b = qi / 4;
      if (op == 3)               slv_low = (b == 8) && slv_ack;
      else if (op == 6 || op == 7) slv_low = (b < 8) && !slv_byte[7-b];
      else                       slv_low = 1'b0;
      e = want(op, q, b, m_data);
      if ({scl_oe, sda_oe} !== e) begin
        if (bad == 0) begin first_c = c; first_act = {scl_oe, sda_oe}; first_exp = e; end
        bad++;
      end
      if (inject && c == 3) begin reg_addr = 4'd2; reg_wdata = 8'h8A; reg_wr = 1'b1; end
      if (inject && c == 5) begin reg_addr = 4'd2; reg_rd = 1'b1; end
      if (inject && c == 6) chk(reg_rdata[7] == 1'b1, "R3", "busy bit while running", reg_rdata, 8'h80 | op);
    end
    chk(bad == 0, req, $sformatf("waveform op %0d (first cycle %0d)", op, first_c), first_act, first_exp);
    @(negedge clk);
    slv_low = 1'b0;
    case (op)
      1, 2: begin m_held = 1; m_hold_low = 1; end
      10:   begin m_held = 0; m_hold_low = 0; end
      3:    m_hold_low = 0;
      6:    m_hold_low = 1;
      7:    m_hold_low = 0;
      default: ;
    endcase
    if (op == 6 || op == 7) m_data = slv_byte;
    idle_lines(req);
    done_checks(op, st, req);
  endtask

  task automatic run_abort(input int op, input string req);
    logic s0, d0;
    s0 = scl_oe; d0 = sda_oe;
    reg_write(2, 8'h80 | op);
    chk(scl_oe == s0 && sda_oe == d0, req, "lines untouched by abort", {scl_oe, sda_oe}, {s0, d0});
    done_checks(op, 3, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0 && irq == 0, "R1", "reset outputs", {irq, scl_oe, sda_oe}, 0);
    reg_read(2, v); chk(v == 0, "R1", "reset command reg", v, 0);

    reg_write(1, 0); reg_write(10, 1); m_en = 1;
    reg_write(3, 8'h77); m_data = 8'h77;
    reg_read(1, v);  chk(v == 0, "R1", "divider readback", v, 0);
    reg_read(10, v); chk(v == 1, "R1", "enable readback", v, 1);
    reg_read(3, v);  chk(v == 8'h77, "R1", "data readback", v, 8'h77);

    run_abort(3, "R8");           // byte with no session
    run_cmd(1, 8'h00, 0, 0, 0, "R5");
    run_abort(1, "R8");           // start inside a session
    reg_write(3, 8'hA5); m_data = 8'hA5;
    run_cmd(3, 8'h00, 1, 1, 1, "R6");
    reg_write(3, 8'h3C); m_data = 8'h3C;
    run_cmd(3, 8'h00, 0, 0, 2, "R6");
    run_cmd(2, 8'h00, 0, 0, 0, "R5");

    reg_write(1, 1); cur_len = 32;   // R4 slower quarters
    run_cmd(6, 8'h96, 0, 0, 0, "R7");
    reg_read(3, v); chk(v == 8'h96, "R7", "received byte with ACK", v, 8'h96);
    run_cmd(7, 8'h5A, 0, 0, 0, "R7");
    reg_read(3, v); chk(v == 8'h5A, "R7", "received byte with NACK", v, 8'h5A);
    run_cmd(10, 8'h00, 0, 0, 0, "R4");

    run_abort(10, "R8");          // stop with no session
    run_abort(5, "R8");           // unknown opcode

    // R3 write without launch bit
    reg_write(2, 8'h01);
    reg_read(8, v); chk(v == 0, "R3", "no flag without launch bit", v, 0);
    reg_read(2, v); chk(v == 8'h65, "R3", "command reg unchanged", v, 8'h65);
    idle_lines("R3");

    // R9 irq masked
    reg_write(10, 0); m_en = 0;
    run_abort(5, "R9");
    reg_write(10, 1); m_en = 1;

    // R2 local reset
    reg_write(1, 0); cur_len = 16;
    run_cmd(1, 8'h00, 0, 0, 0, "R2");
    reg_write(0, 1);
    chk(scl_oe == 0 && sda_oe == 0, "R2", "lines released in local reset", {scl_oe, sda_oe}, 0);
    reg_write(2, 8'h83);
    reg_read(8, v); chk(v == 0, "R2", "launch ignored in local reset", v, 0);
    reg_write(0, 0); m_held = 0; m_hold_low = 0;
    idle_lines("R2");
    run_abort(3, "R2");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule